// File: doc/BRIEF.md
# Crosspoint Routing Fabric with Cascadable Cell Multiplexers

The fabric is an array of routing cells, one per pin, that share a common pool of pin inputs. Each cell owns one pin output and its enable. A cell builds its output from a 4:1 multiplexer. The four data slots of that multiplexer are tied to four disjoint quarters of the pins. The two select lines, the output enable and a capture enable are each drawn from a fixed quarter of the pins, and each has its own polarity bit. A slot may instead take the direct-only multiplexer result of a neighbouring cell, so a cell and four neighbours together form a 16:1 multiplexer. Neighbour indexing wraps around both ends of the array.

The routing is held in a configuration chain. It is shifted in one bit per clock and committed by a load strobe. Until the first commit, every pin output and enable stays low. Per cell, the configuration picks a combinational or captured data source, a fixed low or high level, an output inversion and an enable mode. Every pin output and enable is registered.

Top module: `xp_fabric`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `pin_out` and `pin_oe` are all zero.
- R2: Until the first commit after reset, `pin_out` and `pin_oe` stay zero, whatever is shifted in or driven on `pin_in`.
- R3: When `cfg_shift` is high, the chain shifts `cfg_bit` in at bit 0. After N*W shifts, the first bit shifted sits at bit N*W-1. Cell c takes bits [c*W +: W], where W = 8*S+13 and S = log2(N/4). The chain is committed to the active routing only on a clock where `cfg_load` is high and `cfg_shift` is low. Otherwise the active routing does not change.
- R4: The cell fields, from bit 0 of the cell upward, are:
  - four slot indexes of S bits each, slot k first;
  - four neighbour bits;
  - sel0 index, sel0 polarity;
  - sel1 index, sel1 polarity;
  - enable-pin index, enable-pin polarity, 2-bit enable mode;
  - capture index, capture polarity;
  - 2-bit output mode;
  - invert bit.

  A direct slot k reads pin k*(N/4)+index.
- R5: sel0 is pin 2*(N/4)+index XOR its polarity. sel1 is pin 3*(N/4)+index XOR its polarity. The pair {sel1,sel0} picks a slot: 00 picks slot 0, 01 slot 1, 11 slot 2, 10 slot 3.
- R6: When the neighbour bit of slot k is set, the slot carries the direct-only mux result of a neighbour instead of its pin. The neighbour is cell n-2 for slot 0, n-1 for slot 1, n+1 for slot 2 and n+2 for slot 3, taken modulo N. A direct-only result ignores the neighbour bits of the cell that computes it.
- R7: A cell with all four neighbour bits set, whose four neighbours use direct slots, selects any one of 16 pins through the four select lines involved.
- R8: Several cells may route the same input pin at once, each driving it on its own output.
- R9: Enable mode 00 drives `pin_oe` low and mode 01 drives it high. A mode with bit 1 set drives it from pin 0*(N/4)+index XOR its polarity.
- R10: Output mode 01 drives the cell's capture register. That register takes the mux value on each cycle where the committed cell's capture pin, 1*(N/4)+index XOR its polarity, is high.
- R11: Output mode 10 drives a constant 0 and mode 11 a constant 1. Neither is affected by the invert bit.
- R12: In output modes 00 (combinational mux) and 01 (captured), the invert bit flips the value driven.
- R13: `pin_out` and `pin_oe` reflect `pin_in` and the active routing of the previous clock, one register stage later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the chain, capture registers and output registers |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | N_CELLS | Pin input values feeding the routing pool |
| cfg_shift | input | 1 | Shift one configuration bit this cycle |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_load | input | 1 | Commit the shifted chain to the active routing |
| pin_out | output | N_CELLS | Registered pin output values |
| pin_oe | output | N_CELLS | Registered pin output enables |

## Verification
The hardest state to reach from the ports is a full 16:1 cascade, with each of its 16 paths exercised. This needs the centre cell and four neighbours configured together. The two select pairs must sit on distinct select pins so that they can vary independently. The stimulus does this at an interior cell and again at cell 0, where two neighbours wrap to the top of the array. It walks all 16 combinations of the four select pins, with random data on the rest. Random whole-array configurations then mix neighbour slots, polarities, enable modes, captured paths and fixed levels, and a behavioural model follows every cycle.

// File: rtl/xp_pkg.sv
`timescale 1ns/1ps
package xp_pkg;

  typedef enum logic [1:0] {
    OUT_MUX  = 2'b00,
    OUT_HOLD = 2'b01,
    OUT_LOW  = 2'b10,
    OUT_HIGH = 2'b11
  } out_mode_e;

  // Select pair to slot: reflected ordering, one line changes per step.
  function automatic logic [1:0] slot_of(input logic s1, input logic s0);
    case ({s1, s0})
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  // Neighbour cell feeding slot k of cell c, circular over n cells.
  function automatic int nbr_index(input int c, input int k, input int n);
    int ofs;
    case (k)
      0:       ofs = -2;
      1:       ofs = -1;
      2:       ofs = 1;
      default: ofs = 2;
    endcase
    return (c + ofs + n) % n;
  endfunction

endpackage

// File: rtl/xp_cfg_chain.sv
`timescale 1ns/1ps
module xp_cfg_chain #(
  parameter int TOTAL_W = 464
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic               shift_bit,
  input  logic               load,
  output logic [TOTAL_W-1:0] active,
  output logic               loaded
);

  logic [TOTAL_W-1:0] chain_q;
  logic               commit;

  assign commit = load && !shift_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
    end else if (shift_en) begin
      chain_q <= {chain_q[TOTAL_W-2:0], shift_bit};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= '0;
      loaded <= 1'b0;
    end else if (commit) begin
      active <= chain_q;
      loaded <= 1'b1;
    end
  end

endmodule

// File: rtl/xp_cell.sv
`timescale 1ns/1ps
module xp_cell
  import xp_pkg::*;
#(
  parameter int N_PINS = 16,
  parameter int SEL_W  = 2,
  parameter int CELL_W = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loaded,
  input  logic [N_PINS-1:0] pins,
  input  logic [CELL_W-1:0] cfg,
  input  logic [3:0]        nbr_mux,
  output logic              local_mux,
  output logic              pin_q,
  output logic              oe_q
);

  localparam int GRP     = N_PINS / 4;
  localparam int EXP_LSB = 4 * SEL_W;
  localparam int S0_LSB  = EXP_LSB + 4;
  localparam int S0_POL  = S0_LSB + SEL_W;
  localparam int S1_LSB  = S0_POL + 1;
  localparam int S1_POL  = S1_LSB + SEL_W;
  localparam int OE_LSB  = S1_POL + 1;
  localparam int OE_POL  = OE_LSB + SEL_W;
  localparam int OEM_LSB = OE_POL + 1;
  localparam int CE_LSB  = OEM_LSB + 2;
  localparam int CE_POL  = CE_LSB + SEL_W;
  localparam int OM_LSB  = CE_POL + 1;
  localparam int INV_BIT = OM_LSB + 2;

  function automatic logic grp_pin(input logic [N_PINS-1:0] p, input int grp,
                                   input logic [SEL_W-1:0] idx);
    if (int'(idx) < GRP) return p[grp*GRP + int'(idx)];
    return 1'b0;
  endfunction

  logic [3:0] direct;
  logic [1:0] slot;
  logic       sel0, sel1, cap_en, oe_pin;
  logic [3:0] slot_v;
  logic       mux_v, hold_q, out_val, oe_val;
  out_mode_e  omode;

  // Stage 1: pool pins only, no neighbour input (keeps the cascade acyclic).
  always_comb begin
    for (int k = 0; k < 4; k++) begin
      direct[k] = grp_pin(pins, k, cfg[k*SEL_W +: SEL_W]);
    end
    sel0      = grp_pin(pins, 2, cfg[S0_LSB +: SEL_W]) ^ cfg[S0_POL];
    sel1      = grp_pin(pins, 3, cfg[S1_LSB +: SEL_W]) ^ cfg[S1_POL];
    slot      = slot_of(sel1, sel0);
    local_mux = direct[slot];
    oe_pin    = grp_pin(pins, 0, cfg[OE_LSB +: SEL_W]) ^ cfg[OE_POL];
    cap_en    = grp_pin(pins, 1, cfg[CE_LSB +: SEL_W]) ^ cfg[CE_POL];
  end

  // Stage 2: slots may be replaced by neighbour stage-1 results.
  always_comb begin
    for (int k = 0; k < 4; k++) begin
      slot_v[k] = cfg[EXP_LSB + k] ? nbr_mux[k] : direct[k];
    end
    mux_v = slot_v[slot];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
    end else if (loaded && cap_en) begin
      hold_q <= mux_v;
    end
  end

  always_comb begin
    omode = out_mode_e'(cfg[OM_LSB +: 2]);
    case (omode)
      OUT_MUX:  out_val = mux_v ^ cfg[INV_BIT];
      OUT_HOLD: out_val = hold_q ^ cfg[INV_BIT];
      OUT_LOW:  out_val = 1'b0;
      default:  out_val = 1'b1;
    endcase
    oe_val = cfg[OEM_LSB + 1] ? oe_pin : cfg[OEM_LSB];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      pin_q <= loaded && out_val;
      oe_q  <= loaded && oe_val;
    end
  end

endmodule

// File: rtl/xp_fabric.sv
`timescale 1ns/1ps
module xp_fabric
  import xp_pkg::*;
#(
  parameter int N_CELLS = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CELLS-1:0] pin_in,
  input  logic               cfg_shift,
  input  logic               cfg_bit,
  input  logic               cfg_load,
  output logic [N_CELLS-1:0] pin_out,
  output logic [N_CELLS-1:0] pin_oe
);

  localparam int GRP     = N_CELLS / 4;
  localparam int SEL_W   = (GRP > 1) ? $clog2(GRP) : 1;
  localparam int CELL_W  = 8 * SEL_W + 13;
  localparam int TOTAL_W = N_CELLS * CELL_W;

  logic [TOTAL_W-1:0] active_cfg;
  logic               loaded;
  logic [N_CELLS-1:0] local_mux;

  xp_cfg_chain #(.TOTAL_W(TOTAL_W)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_shift),
    .shift_bit(cfg_bit),
    .load     (cfg_load),
    .active   (active_cfg),
    .loaded   (loaded)
  );

  for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
    logic [3:0] nbr;
    for (genvar k = 0; k < 4; k++) begin : g_nbr
      assign nbr[k] = local_mux[nbr_index(c, k, N_CELLS)];
    end

    xp_cell #(.N_PINS(N_CELLS), .SEL_W(SEL_W), .CELL_W(CELL_W)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .loaded   (loaded),
      .pins     (pin_in),
      .cfg      (active_cfg[c*CELL_W +: CELL_W]),
      .nbr_mux  (nbr),
      .local_mux(local_mux[c]),
      .pin_q    (pin_out[c]),
      .oe_q     (pin_oe[c])
    );
  end

endmodule

// File: rtl/xp_fabric_chk.sv
`timescale 1ns/1ps
module xp_fabric_chk #(
  parameter int N_CELLS = 16,
  parameter int SEL_W   = 2,
  parameter int CELL_W  = 29
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        cfg_shift,
  input logic                        cfg_load,
  input logic [N_CELLS-1:0]          pin_out,
  input logic [N_CELLS-1:0]          pin_oe,
  input logic [N_CELLS*CELL_W-1:0]   active_cfg
);

  localparam int OEM_LSB = 7 * SEL_W + 7;
  localparam int OM_LSB  = 8 * SEL_W + 10;

  logic               seen_q;
  logic [N_CELLS-1:0] hi_mask, lo_mask, off_mask;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else if (cfg_load && !cfg_shift) seen_q <= 1'b1;
  end

  always_comb begin
    for (int c = 0; c < N_CELLS; c++) begin
      hi_mask[c]  = active_cfg[c*CELL_W + OM_LSB +: 2] == 2'b11;
      lo_mask[c]  = active_cfg[c*CELL_W + OM_LSB +: 2] == 2'b10;
      off_mask[c] = active_cfg[c*CELL_W + OEM_LSB +: 2] == 2'b00;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out == '0 && pin_oe == '0));

  // R2
  no_drive_before_load_chk: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> (pin_out == '0 && pin_oe == '0));

  // R3
  cfg_only_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_load && !cfg_shift) |-> $stable(active_cfg));

  // R11
  fixed_high_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_out & $past(hi_mask)) == $past(hi_mask));

  // R11
  fixed_low_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_out & $past(lo_mask)) == '0);

  // R9
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & $past(off_mask)) == '0);

endmodule

bind xp_fabric xp_fabric_chk #(.N_CELLS(N_CELLS), .SEL_W(SEL_W), .CELL_W(CELL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_shift (cfg_shift),
  .cfg_load  (cfg_load),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .active_cfg(active_cfg)
);

// File: tb/tb_xp_fabric.sv
`timescale 1ns/1ps
module tb_xp_fabric;

  localparam int N   = 16;
  localparam int G   = N / 4;
  localparam int SW  = $clog2(G);
  localparam int W   = 8 * SW + 13;
  localparam int TOT = N * W;
  localparam int NF  = 19;
  // field indexes in the bench's own model
  localparam int F_EX = 4, F_S0I = 8, F_S0P = 9, F_S1I = 10, F_S1P = 11;
  localparam int F_OEI = 12, F_OEP = 13, F_OEM = 14, F_CEI = 15, F_CEP = 16;
  localparam int F_OM = 17, F_INV = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pin_in = '0;
  logic         cfg_shift = 1'b0;
  logic         cfg_bit = 1'b0;
  logic         cfg_load = 1'b0;
  logic [N-1:0] pin_out, pin_oe;

  always #2.5 clk = ~clk;

  xp_fabric #(.N_CELLS(N)) dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .cfg_shift(cfg_shift),
    .cfg_bit(cfg_bit), .cfg_load(cfg_load), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int     stg [N][NF];
  int     act [N][NF];
  logic [N-1:0] e_out, e_oe, hold;
  bit     m_loaded;
  int     checks = 0, fails = 0, cycles = 0;
  string  cur_req = "R1";
  bit     done = 0;

  function automatic int gray(input int s1, input int s0);
    case ({s1[0], s0[0]})
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int offs(input int k);
    case (k) 0: return -2; 1: return -1; 2: return 1; default: return 2; endcase
  endfunction

  function automatic int gpin(input int grp, input int idx, input logic [N-1:0] p);
    return (idx < G) ? int'(p[grp*G + idx]) : 0;
  endfunction

  function automatic int sel_slot(input int c, input logic [N-1:0] p);
    int s0, s1;
    s0 = gpin(2, act[c][F_S0I], p) ^ act[c][F_S0P];
    s1 = gpin(3, act[c][F_S1I], p) ^ act[c][F_S1P];
    return gray(s1, s0);
  endfunction

  function automatic int direct_only(input int c, input logic [N-1:0] p);
    int k;
    k = sel_slot(c, p);
    return gpin(k, act[c][k], p);
  endfunction

  function automatic int cell_mux(input int c, input logic [N-1:0] p);
    int k;
    k = sel_slot(c, p);
    if (act[c][F_EX + k] != 0) return direct_only((c + offs(k) + N) % N, p);
    return gpin(k, act[c][k], p);
  endfunction

  // behavioural reference, one step per clock
  always @(posedge clk) begin
    if (rst) begin
      e_out = '0; e_oe = '0; hold = '0; m_loaded = 0;
      for (int c = 0; c < N; c++) for (int f = 0; f < NF; f++) act[c][f] = 0;
    end else begin
      logic [N-1:0] nh;
      nh = hold;
      for (int c = 0; c < N; c++) begin
        int m, v, oe;
        m = cell_mux(c, pin_in);
        case (act[c][F_OM])
          0: v = m ^ act[c][F_INV];
          1: v = int'(hold[c]) ^ act[c][F_INV];
          2: v = 0;
          default: v = 1;
        endcase
        if (act[c][F_OEM] >= 2) oe = gpin(0, act[c][F_OEI], pin_in) ^ act[c][F_OEP];
        else oe = act[c][F_OEM];
        e_out[c] = m_loaded && (v != 0);
        e_oe[c]  = m_loaded && (oe != 0);
        if (m_loaded && ((gpin(1, act[c][F_CEI], pin_in) ^ act[c][F_CEP]) != 0))
          nh[c] = (m != 0);
      end
      hold = nh;
      if (cfg_load && !cfg_shift) begin
        act = stg;
        m_loaded = 1;
      end
    end
  end

  // per-cycle comparison, sampled after the edge
  always @(posedge clk) begin
    #1;
    if (!done) begin
      checks++;
      if (pin_out !== e_out || pin_oe !== e_oe) begin
        fails++;
        $display("FAIL %s out=%h exp=%h oe=%h exp=%h", cur_req, pin_out, e_out, pin_oe, e_oe);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [TOT-1:0] pack_cfg();
    logic [TOT-1:0] v;
    v = '0;
    for (int c = 0; c < N; c++) begin
      int b;
      b = c * W;
      for (int k = 0; k < 4; k++) begin
        v[b + k*SW +: SW] = SW'(stg[c][k]);
        v[b + 4*SW + k]   = stg[c][F_EX + k][0];
      end
      v[b + 4*SW + 4 +: SW] = SW'(stg[c][F_S0I]);
      v[b + 5*SW + 4]       = stg[c][F_S0P][0];
      v[b + 5*SW + 5 +: SW] = SW'(stg[c][F_S1I]);
      v[b + 6*SW + 5]       = stg[c][F_S1P][0];
      v[b + 6*SW + 6 +: SW] = SW'(stg[c][F_OEI]);
      v[b + 7*SW + 6]       = stg[c][F_OEP][0];
      v[b + 7*SW + 7 +: 2]  = 2'(stg[c][F_OEM]);
      v[b + 7*SW + 9 +: SW] = SW'(stg[c][F_CEI]);
      v[b + 8*SW + 9]       = stg[c][F_CEP][0];
      v[b + 8*SW + 10 +: 2] = 2'(stg[c][F_OM]);
      v[b + 8*SW + 12]      = stg[c][F_INV][0];
    end
    return v;
  endfunction

  task automatic shift_cfg();
    logic [TOT-1:0] v;
    v = pack_cfg();
    for (int b = TOT - 1; b >= 0; b--) begin
      @(negedge clk);
      cfg_shift = 1'b1;
      cfg_bit   = v[b];
      pin_in    = N'($urandom);
    end
    @(negedge clk);
    cfg_shift = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic run_random(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pin_in = N'($urandom);
    end
  endtask

  task automatic clear_cell(input int c, input int om);
    for (int f = 0; f < NF; f++) stg[c][f] = 0;
    stg[c][F_OEM] = 1;
    stg[c][F_OM]  = om;
  endtask

  task automatic rand_cell(input int c);
    for (int k = 0; k < 4; k++) begin
      stg[c][k]        = $urandom_range(0, G - 1);
      stg[c][F_EX + k] = ($urandom_range(0, 2) == 0);
    end
    stg[c][F_S0I] = $urandom_range(0, G - 1); stg[c][F_S0P] = $urandom_range(0, 1);
    stg[c][F_S1I] = $urandom_range(0, G - 1); stg[c][F_S1P] = $urandom_range(0, 1);
    stg[c][F_OEI] = $urandom_range(0, G - 1); stg[c][F_OEP] = $urandom_range(0, 1);
    stg[c][F_OEM] = $urandom_range(0, 3);
    stg[c][F_CEI] = $urandom_range(0, G - 1); stg[c][F_CEP] = $urandom_range(0, 1);
    stg[c][F_OM]  = $urandom_range(0, 3);
    stg[c][F_INV] = $urandom_range(0, 1);
  endtask

  // R7 and R6: 16:1 cascade centred on ctr, all select combinations
  task automatic cascade(input int ctr);
    for (int c = 0; c < N; c++) clear_cell(c, 2);
    clear_cell(ctr, 0);
    for (int k = 0; k < 4; k++) stg[ctr][F_EX + k] = 1;
    for (int k = 0; k < 4; k++) begin
      int nb;
      nb = (ctr + offs(k) + N) % N;
      clear_cell(nb, 0);
      for (int j = 0; j < 4; j++) stg[nb][j] = $urandom_range(0, G - 1);
      stg[nb][F_S0I] = 1;
      stg[nb][F_S1I] = 1;
    end
    shift_cfg();
    commit();
    for (int combo = 0; combo < 16; combo++) begin
      logic [N-1:0] p;
      int os, is, nb, want;
      p = N'($urandom);
      p[2*G]     = combo[0];
      p[3*G]     = combo[1];
      p[2*G + 1] = combo[2];
      p[3*G + 1] = combo[3];
      os   = gray(combo[1], combo[0]);
      nb   = (ctr + offs(os) + N) % N;
      is   = gray(combo[3], combo[2]);
      want = int'(p[is*G + stg[nb][is]]);
      @(negedge clk);
      pin_in = p;
      @(posedge clk);
      #1;
      checks++;
      if (int'(pin_out[ctr]) != want) begin
        fails++;
        $display("FAIL R7 cascade cell %0d combo %0d out=%0d exp=%0d", ctr, combo, pin_out[ctr], want);
      end
    end
  endtask

  initial begin
    for (int c = 0; c < N; c++) for (int f = 0; f < NF; f++) stg[c][f] = 0;
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    run_random(3);

    cur_req = "R2";
    for (int c = 0; c < N; c++) clear_cell(c, 3);
    shift_cfg();
    run_random(10);

    cur_req = "R3 R13";
    commit();
    run_random(20);

    cur_req = "R4 R5 R6 R9 R10 R12";
    for (int r = 0; r < 5; r++) begin
      for (int c = 0; c < N; c++) rand_cell(c);
      shift_cfg();
      commit();
      run_random(60);
    end

    cur_req = "R7 R6";
    cascade(5);
    cascade(0);

    cur_req = "R8";
    for (int c = 0; c < N; c++) begin
      clear_cell(c, 0);
      stg[c][0] = 1;
    end
    shift_cfg();
    commit();
    for (int i = 0; i < 8; i++) begin
      logic [N-1:0] p;
      p = N'($urandom);
      p[2*G] = 1'b0;
      p[3*G] = 1'b0;
      @(negedge clk);
      pin_in = p;
      @(posedge clk);
      #1;
      checks++;
      if (pin_out !== {N{p[1]}}) begin
        fails++;
        $display("FAIL R8 fanout out=%h exp=%h", pin_out, {N{p[1]}});
      end
    end

    cur_req = "R10 R12";
    for (int c = 0; c < N; c++) begin
      clear_cell(c, 1);
      stg[c][0] = $urandom_range(0, G - 1);
      stg[c][F_CEI] = c % G;
      stg[c][F_CEP] = c % 2;
      stg[c][F_INV] = (c / 2) % 2;
    end
    shift_cfg();
    commit();
    run_random(40);

    cur_req = "R11 R9";
    for (int c = 0; c < N; c++) begin
      clear_cell(c, 2 + (c % 2));
      stg[c][F_INV] = 1;
      stg[c][F_OEM] = c % 4;
      stg[c][F_OEI] = c % G;
    end
    shift_cfg();
    commit();
    run_random(20);

    cur_req = "R1";
    @(negedge clk);
    rst = 1'b1;
    run_random(3);
    rst = 1'b0;
    run_random(3);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule